// File: doc/BRIEF.md
# SPI Master Channel with Packet Counter

This block is a single SPI master channel driven through a small word-addressed register port. Software pushes transmit words into a transmit FIFO and pops received words from a receive FIFO. Between them, a shift engine moves 8-, 16- or 32-bit words most significant bit first. It works in any of the four clock polarity and phase combinations, and its serial clock comes from an internal prescaler.

A packet counter lets the channel run on its own. Software loads a word count with the receive path enabled, and the engine then produces exactly that many words of clocks and captures the incoming data. This works even when no transmit data has been written, in which case zeros are shifted out. A soft-reset control bit empties both FIFOs and halts the engine. The slave-select line is either forced by software or follows the engine's activity.

The engine uses four states. `ST_IDLE` waits for a start condition. On start it moves to `ST_LEAD`, which waits one prescaler tick and then produces the leading clock edge before moving to `ST_TRAIL`. `ST_TRAIL` waits one tick and produces the trailing edge. From there the engine goes back to `ST_LEAD` if bits remain, or on to `ST_DONE` after the last bit. `ST_DONE` lasts one cycle: it delivers the word and decrements the packet counter, then returns to `ST_IDLE`. Soft reset sends every state to `ST_IDLE`.

Top module: `spi_pkt_master`

## Requirements
- R1: Reset state: the status register at address 5 reads 0, `sck` is 0, `ss_n` is 1 and `rx_empty` is 1.
- R2: With packet counting disabled and transmit enabled, the engine pops one entry per word and shifts it out on `mosi`, most significant bit first. The transmit enable is bit 0 of the channel register at address 0. The word width comes from bits 30:29 of the mode register at address 2: 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits. Bits 18:17 of that register are held only.
- R3: Received bits are taken from `miso` most significant bit first. A finished word is pushed into the receive FIFO only when receive enable (channel register bit 1) is 1.
- R4: Channel register bit 3 sets the idle level of `sck`. Channel register bit 2 selects sampling on the leading edge (0) or the trailing edge (1); the other edge of each pair changes `mosi`. A word produces exactly 2×width edges and ends at the idle level.
- R5: Consecutive `sck` edges are (P+1) clock cycles apart, where P is bits 7:0 of the clock register at address 1. No word starts while enable bit 8 of that register is 0.
- R6: The packet register at address 4 holds a 16-bit count in bits 15:0 and an enable in bit 16. When the enable and receive are both on, words run until the count, which drops by one per finished word, reaches zero. No transmit data is needed.
- R7: While channel register bit 5 is 1, both FIFOs are empty and their levels read 0. Status bits 7:0 give the transmit level, bits 15:8 the receive level, and bit 16 is busy.
- R8: Select register (address 3): with bit 1 at 0, `ss_n` equals bit 0. With bit 1 at 1, `ss_n` is 0 exactly while the engine is busy.
- R9: Address 6 holds a 2-bit delay value that reads back through bits 1:0.
- R10: With packet counting off, the engine stops in `ST_IDLE` with `sck` at its idle level once the transmit FIFO is empty, and it does not start again until a new entry arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_push | input | 1 | Push one word into the transmit FIFO |
| tx_wdata | input | 32 | Transmit word, right-aligned |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Pop the head of the receive FIFO |
| rx_rdata | output | 32 | Head of the receive FIFO, right-aligned |
| rx_empty | output | 1 | Receive FIFO empty |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Slave select, active low |

## Verification
The assertions assume that software leaves the mode, polarity, phase and prescaler fields unchanged while a word is in flight. They also assume that the packet register is not rewritten while it is counting down; a write in that cycle is excluded from the countdown property. The stimulus rewrites configuration only after status shows the engine idle with an empty transmit FIFO. A bench slave drives `miso` only on the shift edge of the chosen mode, so the sampled value is always settled.

// File: rtl/spi_pkt_pkg.sv
`timescale 1ns/1ps
package spi_pkt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2,
        ST_DONE  = 2'd3
    } eng_state_t;

    localparam logic [2:0] A_CHAN   = 3'd0;
    localparam logic [2:0] A_CLOCK  = 3'd1;
    localparam logic [2:0] A_MODE   = 3'd2;
    localparam logic [2:0] A_SELECT = 3'd3;
    localparam logic [2:0] A_PACKET = 3'd4;
    localparam logic [2:0] A_STATUS = 3'd5;
    localparam logic [2:0] A_DELAY  = 3'd6;

    function automatic logic [5:0] word_bits(input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 6'd8;
            2'd1:    return 6'd16;
            default: return 6'd32;
        endcase
    endfunction
endpackage

// File: rtl/spi_fifo.sv
`timescale 1ns/1ps
module spi_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = PTR_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [LVL_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == LVL_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp_q];
    assign level   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0; rp_q <= '0; cnt_q <= '0;
        end else if (flush) begin
            wp_q <= '0; rp_q <= '0; cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/spi_prescale.sv
`timescale 1ns/1ps
module spi_prescale #(
    parameter int PSR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSR_W-1:0] psr,
    output logic             tick
);
    logic [PSR_W-1:0] cnt_q;

    assign tick = run && (cnt_q == psr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (!run)  cnt_q <= '0;
        else if (tick)  cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine
    import spi_pkt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              clk_en,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [1:0]        size,
    input  logic              tx_on,
    input  logic              rx_on,
    input  logic              pkt_en,
    input  logic              pkt_nz,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              miso,
    input  logic              tick,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word,
    output logic              word_done,
    output logic              busy,
    output logic              run,
    output logic              sck,
    output logic              mosi
);
    localparam int CNT_W = $clog2(DATA_W) + 1;

    eng_state_t        state_q, state_d;
    logic [CNT_W-1:0]  bits_q;
    logic [DATA_W-1:0] txs_q, rxs_q, aligned;
    logic              mosi_q, act_q, start, have_tx;
    logic [5:0]        nbits;

    assign nbits   = word_bits(size);
    assign have_tx = tx_on && !tx_empty;
    assign start   = clk_en && (pkt_en ? (rx_on && pkt_nz) : have_tx);
    assign aligned = have_tx ? (tx_data << (6'd32 - nbits)) : '0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LEAD;
            ST_LEAD:  if (tick)  state_d = ST_TRAIL;
            ST_TRAIL: if (tick)  state_d = (bits_q == '0) ? ST_DONE : ST_LEAD;
            ST_DONE:  state_d = ST_IDLE;
        endcase
        if (halt) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0; txs_q <= '0; rxs_q <= '0; mosi_q <= 1'b0; act_q <= 1'b0;
        end else if (halt) begin
            act_q <= 1'b0; mosi_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    bits_q <= CNT_W'(nbits - 6'd1);
                    rxs_q  <= '0;
                    if (!cpha) begin
                        mosi_q <= aligned[DATA_W-1];
                        txs_q  <= aligned << 1;
                    end else begin
                        txs_q  <= aligned;
                    end
                end
                ST_LEAD: if (tick) begin
                    act_q <= 1'b1;
                    if (cpha) begin
                        mosi_q <= txs_q[DATA_W-1];
                        txs_q  <= txs_q << 1;
                    end else begin
                        rxs_q  <= {rxs_q[DATA_W-2:0], miso};
                    end
                end
                ST_TRAIL: if (tick) begin
                    act_q <= 1'b0;
                    if (cpha) begin
                        rxs_q <= {rxs_q[DATA_W-2:0], miso};
                    end else if (bits_q != '0) begin
                        mosi_q <= txs_q[DATA_W-1];
                        txs_q  <= txs_q << 1;
                    end
                    if (bits_q != '0) bits_q <= bits_q - 1'b1;
                end
                ST_DONE: ;
            endcase
        end
    end

    assign tx_pop    = (state_q == ST_IDLE) && start && have_tx && !halt;
    assign word_done = (state_q == ST_DONE);
    assign rx_push   = word_done && rx_on;
    assign rx_word   = rxs_q;
    assign busy      = (state_q != ST_IDLE);
    assign run       = (state_q == ST_LEAD) || (state_q == ST_TRAIL);
    assign sck       = cpol ^ act_q;
    assign mosi      = mosi_q;

    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (sck == cpol)); // R4
    AST_DONE_AFTER_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> ($past(state_q) == ST_TRAIL)); // R2
    AST_GATED_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !clk_en) |=> (state_q == ST_IDLE)); // R5
endmodule

// File: rtl/spi_pkt_master.sv
`timescale 1ns/1ps
module spi_pkt_master
    import spi_pkt_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int PSR_W      = 8,
    parameter int CNT_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tx_push,
    input  logic [31:0] tx_wdata,
    output logic        tx_full,
    input  logic        rx_pop,
    output logic [31:0] rx_rdata,
    output logic        rx_empty,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        ss_n
);
    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

    logic [6:0]       chan_q;
    logic [PSR_W:0]   clkcfg_q;
    logic [1:0]       ch_sz_q, bus_sz_q, sel_q, delay_q;
    logic             pkt_en_q;
    logic [CNT_W-1:0] pkt_cnt_q;

    logic             soft_rst, tx_empty, tx_pop, rx_push, rx_full, word_done;
    logic             busy, run, tick, pkt_wr;
    logic [31:0]      tx_head, rx_word;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    logic             unused_bits;

    assign soft_rst    = chan_q[5];
    assign pkt_wr      = reg_wr && (reg_addr == A_PACKET);
    assign unused_bits = ^{reg_wdata[31], reg_wdata[28:19], rx_full};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0; clkcfg_q <= '0; ch_sz_q <= '0; bus_sz_q <= '0;
            sel_q <= 2'b01; delay_q <= '0; pkt_en_q <= 1'b0; pkt_cnt_q <= '0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    A_CHAN:   chan_q   <= reg_wdata[6:0];
                    A_CLOCK:  clkcfg_q <= reg_wdata[PSR_W:0];
                    A_MODE:   begin ch_sz_q <= reg_wdata[30:29]; bus_sz_q <= reg_wdata[18:17]; end
                    A_SELECT: sel_q    <= reg_wdata[1:0];
                    A_DELAY:  delay_q  <= reg_wdata[1:0];
                    default:  ;
                endcase
            end
            if (pkt_wr) begin
                pkt_en_q  <= reg_wdata[16];
                pkt_cnt_q <= reg_wdata[CNT_W-1:0];
            end else if (word_done && pkt_en_q && pkt_cnt_q != '0) begin
                pkt_cnt_q <= pkt_cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CHAN:   reg_rdata = {25'b0, chan_q};
            A_CLOCK:  reg_rdata = 32'(clkcfg_q);
            A_MODE:   reg_rdata = {1'b0, ch_sz_q, 10'b0, bus_sz_q, 17'b0};
            A_SELECT: reg_rdata = {30'b0, sel_q};
            A_PACKET: reg_rdata = {15'b0, pkt_en_q, 16'(pkt_cnt_q)};
            A_STATUS: reg_rdata = {15'b0, busy, 8'(rx_lvl), 8'(tx_lvl)};
            A_DELAY:  reg_rdata = {30'b0, delay_q};
            default:  reg_rdata = '0;
        endcase
    end

    spi_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_head),
        .full(tx_full), .empty(tx_empty), .level(tx_lvl)
    );

    spi_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .push(rx_push), .wdata(rx_word), .pop(rx_pop), .rdata(rx_rdata),
        .full(rx_full), .empty(rx_empty), .level(rx_lvl)
    );

    spi_prescale #(.PSR_W(PSR_W)) u_prescale (
        .clk(clk), .rst_n(rst_n), .run(run), .psr(clkcfg_q[PSR_W-1:0]), .tick(tick)
    );

    spi_shift_engine #(.DATA_W(32)) u_engine (
        .clk(clk), .rst_n(rst_n), .halt(soft_rst), .clk_en(clkcfg_q[PSR_W]),
        .cpol(chan_q[3]), .cpha(chan_q[2]), .size(ch_sz_q),
        .tx_on(chan_q[0]), .rx_on(chan_q[1]),
        .pkt_en(pkt_en_q), .pkt_nz(pkt_cnt_q != '0),
        .tx_empty(tx_empty), .tx_data(tx_head), .miso(miso), .tick(tick),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word), .word_done(word_done),
        .busy(busy), .run(run), .sck(sck), .mosi(mosi)
    );

    assign ss_n = sel_q[1] ? !busy : sel_q[0];

    AST_PKT_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && pkt_en_q && pkt_cnt_q != '0 && !pkt_wr)
        |=> (pkt_cnt_q == $past(pkt_cnt_q) - 1'b1)); // R6
    AST_SOFT_RESET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (tx_lvl == '0 && rx_lvl == '0)); // R7
endmodule

// File: tb/spi_pkt_master_bench.sv
`timescale 1ns/1ps
module spi_pkt_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_push = 1'b0;
    logic [31:0] tx_wdata = '0;
    logic        tx_full;
    logic        rx_pop = 1'b0;
    logic [31:0] rx_rdata;
    logic        rx_empty;
    logic        sck, mosi, ss_n;
    logic        miso = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench-side slave and monitor state
    logic        cur_cpol = 1'b0, cur_cpha = 1'b0, miso_hold = 1'b0;
    logic [31:0] resp = '0, mon = '0;
    int          idx = -1, edges = 0;
    time         t_first = 0, t_last = 0;

    always #2 clk = ~clk;

    spi_pkt_master u_spi_pkt_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_push(tx_push),
        .tx_wdata(tx_wdata), .tx_full(tx_full), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_empty(rx_empty), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    always @(sck) begin
        logic lead;
        if (rst_n) begin
            if (edges == 0) t_first = $time;
            t_last = $time;
            edges++;
            lead = (sck != cur_cpol);
            #1;
            if (lead ^ cur_cpha) mon = {mon[30:0], mosi};
            if (!miso_hold && (lead == cur_cpha) && idx >= 0) begin
                miso = resp[idx];
                idx--;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk); tx_push = 1'b1; tx_wdata = d;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic clear_mon();
        repeat (3) @(negedge clk);
        mon = '0; edges = 0; t_first = 0; t_last = 0;
    endtask

    task automatic wait_idle(input int want_rx, input string req);
        logic [31:0] st;
        bit ok = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 6000; i++) begin
            rd(3'd5, st);
            if (!st[16] && st[7:0] == 0 && st[15:8] == 8'(want_rx)) begin ok = 1; break; end
        end
        chk(req, 32'(ok), 32'd1);
    endtask

    task automatic run_word(input int m, input int sz, input int psr,
                            input logic [31:0] txw, input logic [31:0] rsp);
        int nb;
        logic [31:0] mask;
        nb   = 8 << sz;
        mask = (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 1);
        wr(3'd1, 32'h100 | 32'(psr));
        wr(3'd2, 32'(sz) << 29);
        wr(3'd0, 32'h3 | (32'(m) << 2));
        wr(3'd3, 32'h3);
        cur_cpol = m[1]; cur_cpha = m[0];
        clear_mon();
        resp = rsp;
        if (!cur_cpha) begin miso = rsp[nb-1]; idx = nb - 2; end
        else           begin idx = nb - 1; end
        push(txw);
        wait_idle(1, "R10 word completes");
        chk("R2 mosi word MSB first", mon & mask, txw & mask);
        chk("R3 received word", rx_rdata, rsp & mask);
        chk("R4 edge count", 32'(edges), 32'(2 * nb));
        chk("R4 sck idle level", 32'(sck), 32'(cur_cpol));
        chk("R5 edge spacing", 32'(t_last - t_first), 32'((2 * nb - 1) * (psr + 1) * 4));
        chk("R8 auto select idle", 32'(ss_n), 32'd1);
        pop();
        idx = -1;
    endtask

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(3'd5, v);
        chk("R1 status", v, 32'h0);
        chk("R1 sck", 32'(sck), 32'd0);
        chk("R1 ss_n", 32'(ss_n), 32'd1);
        chk("R1 rx_empty", 32'(rx_empty), 32'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4 R5 sweep: all modes, all widths, two prescales
        for (int m = 0; m < 4; m++)
            for (int sz = 0; sz < 3; sz++)
                for (int p = 0; p < 2; p++) begin
                    int k;
                    k = m * 6 + sz * 2 + p;
                    run_word(m, sz, p, 32'hA5C3_96E1 ^ (32'(k) * 32'h0101_0111),
                             32'h5F1E_2D3C + 32'(k) * 32'h0013_0707);
                end
        run_word(2, 0, 3, 32'h0000_00C6, 32'h0000_0039);

        // R3 receive disabled: word shifts but nothing is stored
        wr(3'd0, 32'h1);
        clear_mon();
        push(32'h0000_0077);
        wait_idle(0, "R3 rx disabled completes");
        chk("R3 nothing stored", 32'(rx_empty), 32'd1);
        chk("R3 word still clocked", 32'(edges), 32'd16);

        // R5 clock enable gating, then R7 soft reset flush
        wr(3'd1, 32'h000);
        wr(3'd0, 32'h3);
        clear_mon();
        push(32'h11); push(32'h22); push(32'h33);
        repeat (20) @(negedge clk);
        rd(3'd5, v);
        chk("R5 gated, no start", v, 32'h0000_0003);
        chk("R5 gated, no edges", 32'(edges), 32'd0);
        wr(3'd0, 32'h23);
        rd(3'd5, v);
        chk("R7 flush levels", v, 32'h0);
        wr(3'd0, 32'h3);
        wr(3'd1, 32'h100);
        repeat (20) @(negedge clk);
        chk("R10 no start when empty", 32'(edges), 32'd0);

        // R6 packet count, receive only, no transmit data
        wr(3'd2, 32'h0);
        wr(3'd0, 32'h2);
        cur_cpol = 1'b0; cur_cpha = 1'b0;
        miso_hold = 1'b1; miso = 1'b1;
        clear_mon();
        wr(3'd4, 32'h0001_0003);
        wait_idle(3, "R6 packet run completes");
        rd(3'd4, v);
        chk("R6 counter reaches zero", v, 32'h0001_0000);
        chk("R6 captured word", rx_rdata, 32'h0000_00FF);
        chk("R6 edges for three words", 32'(edges), 32'd48);
        chk("R6 mosi zeros", mon, 32'h0);
        pop(); pop(); pop();
        chk("R6 three words drained", 32'(rx_empty), 32'd1);
        miso_hold = 1'b0;

        // R8 software select
        wr(3'd3, 32'h0);
        #1 chk("R8 forced active", 32'(ss_n), 32'd0);
        wr(3'd3, 32'h1);
        #1 chk("R8 forced inactive", 32'(ss_n), 32'd1);

        // R9 delay register
        wr(3'd6, 32'hFF);
        rd(3'd6, v);
        chk("R9 delay readback", v, 32'h3);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule